// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a stream of oscillator enables, nominally 32,768 per second, into a one-clock pulse once per second, and trims the long-term rate in software-chosen steps. The divider is built as a fine stage of 128 oscillator enables feeding a coarse stage that counts those 128-enable units. All rate correction happens in the coarse stage, so a corrected second is longer or shorter by a whole number of units.

A 64-minute cycle governs when trimming occurs. A five-bit magnitude N and a direction bit choose the trim. In each of the first 2N minutes of the cycle, the first second of the minute is adjusted and every other second stays nominal. A fast trim removes two units (256 enables) from that second. A slow trim adds one unit (128 enables). A magnitude of 31 therefore adjusts minutes 0 to 61, and minutes 62 and 63 always run at the nominal rate. The calibration inputs are captured only at minute boundaries, so no second is ever partly adjusted. While the run control is low, the captured value follows the inputs directly.

A run control freezes the whole chain. A minute-position output exposes the 64-minute counter so that a test can follow where the cycle stands.

Top module: `cal_prescaler`

## Requirements
- R1: With a captured magnitude of 0, every second lasts exactly 2^(PRE_W+UNIT_W) oscillator enables (32,768 with the default parameters).
- R2: With the direction bit at 1 (fast), an adjusted second lasts 256 oscillator enables fewer than nominal (two fine-stage units).
- R3: With the direction bit at 0 (slow), an adjusted second lasts 128 oscillator enables more than nominal (one fine-stage unit).
- R4: Only the first second of a minute can be adjusted. It is adjusted exactly when the minute position is below 2N, where N is the captured magnitude. All other seconds are nominal.
- R5: With a magnitude of 31, minutes 0 to 61 each carry one adjusted second and minutes 62 and 63 carry none.
- R6: `min_pos` increments by one each time the last second of a minute completes (SEC_PER_MIN seconds, 60 by default) and wraps from 63 to 0.
- R7: While run is high, a change on `cal_mag` or `cal_fast` leaves the current minute untouched, including a second already in progress. The change takes effect from the next minute boundary.
- R8: While run is low, oscillator enables are ignored, all counts hold, no tick is issued, and the captured calibration follows the inputs directly.
- R9: Synchronous reset clears the tick, both counters and the captured calibration (magnitude 0). If run is held high, new inputs are first captured at the first minute boundary after reset.
- R10: `sec_tick` is high for exactly one clock: the clock after the oscillator enable that completes the second.
- R11: The length of a second is counted in oscillator enables, not in clocks. Idle clocks between enables do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-clock enable per oscillator cycle |
| run | input | 1 | 1 = count, 0 = freeze and load calibration directly |
| cal_mag | input | 5 | Trim magnitude N, 0 to 31 |
| cal_fast | input | 1 | Trim direction, 1 = fast (shorten), 0 = slow (lengthen) |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| min_pos | output | 6 | Position within the 64-minute correction cycle |

## Verification
If the fine or coarse counter holds a wrong value, the length of the second in progress changes. The error is visible at the very next `sec_tick`, as an interval that differs from nominal or from the trimmed length. If the minute or second index is wrong, the adjusted second lands in the wrong place, or a minute that should be trimmed is not. This first shows at the next minute boundary, either through `min_pos` or through one interval of the wrong length. A wrong captured calibration may stay hidden until the first second of a minute inside the window. For that reason the bench drives changes part-way through an adjusted second, during a stop, and right after reset, and it runs whole 64-minute cycles at the extreme magnitude.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CAL_MAG_W     = 5;
    localparam int CAL_MIN_W     = CAL_MAG_W + 1;
    localparam int CAL_WIN_LIMIT = 2 * ((1 << CAL_MAG_W) - 1);

    typedef enum logic [1:0] {
        SEC_NOMINAL = 2'd0,
        SEC_SHORT   = 2'd1,
        SEC_LONG    = 2'd2
    } sec_kind_e;

    typedef struct packed {
        logic                 fast;
        logic [CAL_MAG_W-1:0] mag;
    } cal_set_t;

    // minute position lies inside the trimmed part of the cycle
    function automatic logic in_window(logic [CAL_MIN_W-1:0] pos,
                                       logic [CAL_MAG_W-1:0] mag);
        return pos < {mag, 1'b0};
    endfunction

    function automatic sec_kind_e pick_kind(logic first_sec, logic win, logic fast);
        if (!(first_sec && win)) return SEC_NOMINAL;
        return fast ? SEC_SHORT : SEC_LONG;
    endfunction

endpackage

// File: rtl/cal_unit_div.sv
module cal_unit_div #(
    parameter int PRE_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic osc_en,
    output logic unit_stb
);

    logic [PRE_W-1:0] cnt_q;
    logic             step;

    assign step     = run && osc_en;
    assign unit_stb = step && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // R8: a stopped chain holds its fine count
    a_r8_fine_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));

endmodule

// File: rtl/cal_sec_count.sv
module cal_sec_count
    import cal_pkg::*;
#(
    parameter int UNIT_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      unit_stb,
    input  sec_kind_e kind,
    output logic      sec_done
);

    localparam int CW    = UNIT_W + 1;
    localparam int UNITS = 1 << UNIT_W;
    localparam logic [CW-1:0] LAST_NOM   = CW'(UNITS - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(UNITS - 3);
    localparam logic [CW-1:0] LAST_LONG  = CW'(UNITS);

    logic [CW-1:0] u_q;
    logic [CW-1:0] last;

    always_comb begin
        unique case (kind)
            SEC_SHORT: last = LAST_SHORT;
            SEC_LONG:  last = LAST_LONG;
            default:   last = LAST_NOM;
        endcase
    end

    // >= keeps the count bounded if the kind shrinks during a stop
    assign sec_done = unit_stb && (u_q >= last);

    always_ff @(posedge clk) begin
        if (rst)           u_q <= '0;
        else if (sec_done) u_q <= '0;
        else if (unit_stb) u_q <= u_q + 1'b1;
    end

    // R3: the coarse count never passes the longest second
    a_r3_unit_bound: assert property (@(posedge clk) disable iff (rst)
        u_q <= LAST_LONG);

endmodule

// File: rtl/cal_min_track.sv
module cal_min_track
    import cal_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_done,
    input  cal_set_t             act,
    output sec_kind_e            kind,
    output logic                 min_bound,
    output logic [CAL_MIN_W-1:0] min_q
);

    localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);

    logic [SW-1:0] sidx_q;
    logic          first_sec;

    assign first_sec = (sidx_q == '0);
    assign kind      = pick_kind(first_sec, in_window(min_q, act.mag), act.fast);
    assign min_bound = sec_done && (sidx_q == SEC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sidx_q <= '0;
            min_q  <= '0;
        end else if (min_bound) begin
            sidx_q <= '0;
            min_q  <= min_q + 1'b1;
        end else if (sec_done) begin
            sidx_q <= sidx_q + 1'b1;
        end
    end

    // R5: no adjusted second beyond the last trimmable minute
    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        (kind != SEC_NOMINAL) |-> (int'(min_q) < CAL_WIN_LIMIT));

    // R6: minute position only steps forward by one, wrapping
    a_r6_min_step: assert property (@(posedge clk) disable iff (rst)
        !min_bound |=> $stable(min_q));

    // R4: only the first second of a minute is adjusted
    a_r4_first_only: assert property (@(posedge clk) disable iff (rst)
        (sidx_q != '0) |-> (kind == SEC_NOMINAL));

endmodule

// File: rtl/cal_capture.sv
module cal_capture
    import cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 min_bound,
    input  logic [CAL_MAG_W-1:0] cal_mag,
    input  logic                 cal_fast,
    output cal_set_t             act_q
);

    always_ff @(posedge clk) begin
        if (rst)                    act_q <= '0;
        else if (!run || min_bound) act_q <= '{fast: cal_fast, mag: cal_mag};
    end

    // R7: while running, the captured trim holds inside a minute
    a_r7_hold_mid: assert property (@(posedge clk) disable iff (rst)
        (run && !min_bound) |=> $stable(act_q));

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import cal_pkg::*;
#(
    parameter int PRE_W       = 7,
    parameter int UNIT_W      = 8,
    parameter int SEC_PER_MIN = 60
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 osc_en,
    input  logic                 run,
    input  logic [CAL_MAG_W-1:0] cal_mag,
    input  logic                 cal_fast,
    output logic                 sec_tick,
    output logic [CAL_MIN_W-1:0] min_pos
);

    logic      unit_stb;
    logic      sec_done;
    logic      min_bound;
    sec_kind_e kind;
    cal_set_t  act;
    logic      tick_q;

    cal_unit_div #(.PRE_W(PRE_W)) u_div (
        .clk(clk), .rst(rst), .run(run), .osc_en(osc_en), .unit_stb(unit_stb)
    );

    cal_sec_count #(.UNIT_W(UNIT_W)) u_sec (
        .clk(clk), .rst(rst), .unit_stb(unit_stb), .kind(kind), .sec_done(sec_done)
    );

    cal_min_track #(.SEC_PER_MIN(SEC_PER_MIN)) u_min (
        .clk(clk), .rst(rst), .sec_done(sec_done), .act(act),
        .kind(kind), .min_bound(min_bound), .min_q(min_pos)
    );

    cal_capture u_cap (
        .clk(clk), .rst(rst), .run(run), .min_bound(min_bound),
        .cal_mag(cal_mag), .cal_fast(cal_fast), .act_q(act)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= sec_done;
    end

    assign sec_tick = tick_q;

    // R10: the tick is a single-clock pulse
    a_r10_tick_pulse: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    // R8: no tick follows a stopped cycle
    a_r8_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sec_tick);

endmodule

// File: tb/cal_prescaler_bench.sv
module cal_prescaler_bench;
    import cal_pkg::*;

    localparam int PRE_W  = 2;
    localparam int UNIT_W = 3;
    localparam int SPM    = 4;
    localparam int UNIT   = 1 << PRE_W;
    localparam int NOM    = 1 << (PRE_W + UNIT_W);

    typedef struct packed {
        logic [4:0]  mag;
        logic        fast;
        logic [15:0] nsec;
    } row_t;

    localparam row_t ROWS [5] = '{
        '{5'd0,  1'b0, 16'd6},
        '{5'd1,  1'b1, 16'd260},
        '{5'd3,  1'b0, 16'd30},
        '{5'd31, 1'b1, 16'd256},
        '{5'd31, 1'b0, 16'd256}
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 osc_en;
    logic                 run;
    logic [CAL_MAG_W-1:0] cal_mag;
    logic                 cal_fast;
    logic                 sec_tick;
    logic [CAL_MIN_W-1:0] min_pos;

    int n_cmp = 0;
    int n_bad = 0;
    int m_sec = 0;
    int m_min = 0;
    int a_mag = 0;
    bit a_fast = 1'b0;

    always #5 clk = ~clk;

    cal_prescaler #(.PRE_W(PRE_W), .UNIT_W(UNIT_W), .SEC_PER_MIN(SPM)) u_cal_prescaler (
        .clk(clk), .rst(rst), .osc_en(osc_en), .run(run),
        .cal_mag(cal_mag), .cal_fast(cal_fast),
        .sec_tick(sec_tick), .min_pos(min_pos)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len();
        if (m_sec == 0 && m_min < 2 * a_mag)
            return a_fast ? NOM - 2 * UNIT : NOM + UNIT;
        return NOM;
    endfunction

    // one second: gap idle clocks between enables, optional input change at pulse chg_at
    task automatic run_sec(input int gap, input int chg_at,
                           input logic [4:0] nm, input logic nf, input string tag);
        int len = 0;
        int exp = exp_len();
        string req = tag;
        if (req == "") begin
            if (exp == NOM) req = (a_mag == 0) ? "R1" : ((a_mag == 31) ? "R5" : "R4");
            else if (a_mag == 31) req = "R5";
            else req = a_fast ? "R2" : "R3";
        end
        for (int c = 0; c < 4000; c++) begin
            osc_en = (c % (gap + 1)) == 0;
            if (len == chg_at) begin
                cal_mag  = nm;
                cal_fast = nf;
            end
            @(posedge clk);
            if (osc_en) len++;
            @(negedge clk);
            if (sec_tick) break;
        end
        osc_en = 1'b0;
        check(len == exp, req, len, exp);
        m_sec++;
        if (m_sec == SPM) begin
            m_sec  = 0;
            m_min  = (m_min + 1) % 64;
            a_mag  = int'(cal_mag);
            a_fast = cal_fast;
        end
        check(int'(min_pos) == m_min, "R6", int'(min_pos), m_min);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b0; osc_en = 1'b0; cal_mag = '0; cal_fast = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sec_tick == 1'b0, "R9", int'(sec_tick), 0);
        check(min_pos == '0, "R9", int'(min_pos), 0);
        rst = 1'b0;

        // table walk: each row sets the trim, then runs its seconds
        for (int r = 0; r < 5; r++) begin
            cal_mag  = ROWS[r].mag;
            cal_fast = ROWS[r].fast;
            if (r == 0) begin
                @(negedge clk);
                a_mag  = int'(cal_mag);
                a_fast = cal_fast;
                run    = 1'b1;
            end
            for (int s = 0; s < int'(ROWS[r].nsec); s++)
                run_sec(0, -1, '0, 1'b0, "");
        end

        // R10: tick is gone one clock later
        @(posedge clk);
        @(negedge clk);
        check(sec_tick == 1'b0, "R10", int'(sec_tick), 0);

        // R8: stopped at minute 10 second 0; new trim loads at once, enables ignored
        run = 1'b0; cal_mag = 5'd3; cal_fast = 1'b1;
        a_mag = 3; a_fast = 1'b1;
        for (int c = 0; c < 50; c++) begin
            osc_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(sec_tick == 1'b0, "R8", int'(sec_tick), 0);
        end
        osc_en = 1'b0;
        check(int'(min_pos) == m_min, "R8", int'(min_pos), m_min);
        run = 1'b1;
        run_sec(0, -1, '0, 1'b0, "R8");

        // R11: gapped enables keep the count
        cal_mag = 5'd31; cal_fast = 1'b0;
        for (int s = 0; s < 6; s++) run_sec(2, -1, '0, 1'b0, "R11");

        // R9: reset mid-second with run high clears the captured trim
        for (int c = 0; c < 10; c++) begin
            osc_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        osc_en = 1'b0;
        cal_mag = 5'd3; cal_fast = 1'b1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(min_pos == '0, "R9", int'(min_pos), 0);
        check(sec_tick == 1'b0, "R9", int'(sec_tick), 0);
        rst = 1'b0;
        m_sec = 0; m_min = 0; a_mag = 0; a_fast = 1'b0;
        run_sec(0, -1, '0, 1'b0, "R9");
        for (int s = 0; s < 3; s++) run_sec(0, -1, '0, 1'b0, "");

        // R7: change during an adjusted second leaves it and its minute intact
        run_sec(0, 10, 5'd0, 1'b0, "R7");
        for (int s = 0; s < 3; s++) run_sec(0, -1, '0, 1'b0, "R7");
        run_sec(0, -1, '0, 1'b0, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule